// File: doc/BRIEF.md
# Reset Source Controller with Status

This block merges six reset requests into one internal reset and keeps a record of the cause. The six sources are power-on, the external pin, watchdog timeout, low-voltage inhibit, illegal opcode and illegal address. The external pin is an asynchronous active-low input. The five detector sources arrive as one-clock request pulses on the oscillator clock.

Once the last source is gone, the internal reset stays asserted for a fixed number of clocks and then drops on a clock edge. The block also drives a clear for the system prescaler counter, but only during resets that an internal source started. The reset vector address depends on the monitor-mode flag.

A status byte keeps one flag per source. The pin flag has two conditions. The synchronized pin must be seen low for a minimum number of clocks. No power-on or low-voltage request may have joined the same reset. Software reads the byte with a read strobe, and the byte clears one clock after that strobe.

Top module: `reset_source_ctrl`

## Requirements
- R1: Each source sets its own status bit: bit 7 power-on, bit 6 pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 low-voltage. Bits 1 and 0 always read 0.
- R2: A request pulse sampled on a clock edge makes `irst_o` high after that edge. While the pin is low, `irst_o` is high immediately, without waiting for a clock.
- R3: `irst_o` falls on the 32nd clock edge after the last edge on which a source was seen. For the pin, a source is seen on an edge when its synchronized value is low.
- R4: `psc_clr_o` is high throughout a reset in which a power-on, watchdog, low-voltage, illegal-opcode or illegal-address request was seen, and it falls together with `irst_o`. A reset caused by the pin alone never raises it.
- R5: In user mode (`monitor_i`=0), `vec_hi_o` is 16'hFFFE and `vec_lo_o` is 16'hFFFF. In monitor mode they are 16'hFEFE and 16'hFEFF.
- R6: The pin passes a two-flop synchronizer. The pin bit is set only when the synchronized pin stays low for at least 67 consecutive clock samples. A low pulse of 66 clocks leaves the bit clear.
- R7: The pin bit is not set if a power-on or low-voltage request was seen in the same reset, from its first asserted clock to its release.
- R8: A power-on request loads the status byte with 8'h80. This clears every other bit.
- R9: If `stat_rd_i` is sampled high on one edge, the status byte is 0 after the next edge. A source setting a bit on that next edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Block supply reset, async active low |
| pin_rst_ni | input | 1 | External reset pin, async active low |
| por_req_i | input | 1 | Power-on request pulse |
| wdog_req_i | input | 1 | Watchdog timeout request pulse |
| lvi_req_i | input | 1 | Low-voltage request pulse |
| ill_op_req_i | input | 1 | Illegal-opcode request pulse |
| ill_addr_req_i | input | 1 | Illegal-address request pulse |
| monitor_i | input | 1 | Monitor-mode flag |
| stat_rd_i | input | 1 | Status read strobe |
| irst_o | output | 1 | Internal reset, active high |
| psc_clr_o | output | 1 | Prescaler counter clear |
| vec_hi_o | output | 16 | Address of reset vector high byte |
| vec_lo_o | output | 16 | Address of reset vector low byte |
| status_o | output | 8 | Reset status byte |

## Verification
The bench drives inputs on the falling edge and samples outputs on the falling edge.

| Result | When the bench checks it |
|---|---|
| Status bit of a request pulse | Half a clock after the edge that sampled the pulse |
| `irst_o` and `psc_clr_o` from a request pulse | Same time as the status bit |
| `irst_o` drop (R3) | 31 and then 32 clocks after that edge, so both the last high cycle and the first low cycle are checked |
| `irst_o` from the pin | Asynchronous, checked in the same half cycle the pin is driven low |
| Pin bit (R6) | Depends on the count of synchronized low samples. This equals the number of clocks the pin was driven low, delayed by two flops, so checks wait a full release window before reading status |

The status-read clear is checked one clock after the strobe was sampled. The vector outputs are combinational and are checked in the half cycle after `monitor_i` changes.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned VEC_W  = 16;
  // status bit positions
  localparam int unsigned B_POR  = 7;
  localparam int unsigned B_PIN  = 6;
  localparam int unsigned B_WDOG = 5;
  localparam int unsigned B_IOP  = 4;
  localparam int unsigned B_IAD  = 3;
  localparam int unsigned B_LVI  = 2;
  localparam logic [VEC_W-1:0] VEC_USR_HI = 16'hFFFE;
  localparam logic [VEC_W-1:0] VEC_USR_LO = 16'hFFFF;
  localparam logic [VEC_W-1:0] VEC_MON_HI = 16'hFEFE;
  localparam logic [VEC_W-1:0] VEC_MON_LO = 16'hFEFF;

  typedef struct packed {
    logic por;
    logic wdog;
    logic iop;
    logic iad;
    logic lvi;
  } int_req_t;
endpackage

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PIN_MIN     = 67
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic low_o,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(PIN_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(PIN_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  assign low_o = ~sync_q[SYNC_STAGES-1];
  // one-shot on the sample that reaches the minimum width
  assign hit_o = low_o && (cnt_q == CMAX - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!low_o)      cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int unsigned HOLD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_low_i,
  input  logic int_any_i,
  input  logic mask_src_i,
  output logic hold_o,
  output logic int_o,
  output logic mask_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q;
  logic          hold_q, int_q, mask_q;
  logic          src, ending;

  assign src    = pin_low_i | int_any_i;
  assign ending = !src && (cnt_q == HW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      int_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (src) begin
        cnt_q  <= HW'(HOLD);
        hold_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - HW'(1);
        hold_q <= !ending;
      end
      if (int_any_i)   int_q <= 1'b1;
      else if (ending) int_q <= 1'b0;
      if (mask_src_i)  mask_q <= 1'b1;
      else if (ending) mask_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign int_o  = int_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/rsc_status.sv
module rsc_status
  import rsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] stat_o
);
  logic              rd_q;
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      stat_q <= '0;
    end else begin
      rd_q <= rd_i;
      if (por_i) stat_q <= STAT_W'(1) << B_POR;
      else       stat_q <= (rd_q ? '0 : stat_q) | set_i;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PIN_MIN     = 67,
  parameter int unsigned HOLD        = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_rst_ni,
  input  logic              por_req_i,
  input  logic              wdog_req_i,
  input  logic              lvi_req_i,
  input  logic              ill_op_req_i,
  input  logic              ill_addr_req_i,
  input  logic              monitor_i,
  input  logic              stat_rd_i,
  output logic              irst_o,
  output logic              psc_clr_o,
  output logic [VEC_W-1:0]  vec_hi_o,
  output logic [VEC_W-1:0]  vec_lo_o,
  output logic [STAT_W-1:0] status_o
);
  int_req_t          req;
  logic              int_any, pin_low, pin_hit, hold, mask, mask_src;
  logic [STAT_W-1:0] set_vec;

  assign req      = '{por: por_req_i, wdog: wdog_req_i, iop: ill_op_req_i,
                      iad: ill_addr_req_i, lvi: lvi_req_i};
  assign int_any  = |req;
  assign mask_src = req.por | req.lvi;

  rsc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .PIN_MIN(PIN_MIN)) u_pin (
    .clk_i, .rst_ni, .pin_ni(pin_rst_ni), .low_o(pin_low), .hit_o(pin_hit)
  );

  rsc_stretch #(.HOLD(HOLD)) u_hold (
    .clk_i, .rst_ni, .pin_low_i(pin_low), .int_any_i(int_any),
    .mask_src_i(mask_src), .hold_o(hold), .int_o(psc_clr_o), .mask_o(mask)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_PIN]  = pin_hit & ~mask & ~mask_src;
    set_vec[B_WDOG] = req.wdog;
    set_vec[B_IOP]  = req.iop;
    set_vec[B_IAD]  = req.iad;
    set_vec[B_LVI]  = req.lvi;
  end

  rsc_status u_stat (
    .clk_i, .rst_ni, .por_i(req.por), .set_i(set_vec), .rd_i(stat_rd_i),
    .stat_o(status_o)
  );

  // pin low asserts reset without waiting for a clock
  assign irst_o   = hold | ~pin_rst_ni;
  assign vec_hi_o = monitor_i ? VEC_MON_HI : VEC_USR_HI;
  assign vec_lo_o = monitor_i ? VEC_MON_LO : VEC_USR_LO;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
  import rsc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pin_rst_ni,
  input logic              por_req_i,
  input logic              wdog_req_i,
  input logic              lvi_req_i,
  input logic              ill_op_req_i,
  input logic              ill_addr_req_i,
  input logic              stat_rd_i,
  input logic              irst_o,
  input logic              psc_clr_o,
  input logic [VEC_W-1:0]  vec_hi_o,
  input logic [VEC_W-1:0]  vec_lo_o,
  input logic [STAT_W-1:0] status_o
);
  logic any_req;
  assign any_req = por_req_i | wdog_req_i | lvi_req_i | ill_op_req_i | ill_addr_req_i;

  AST_REQ_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> irst_o) else $error("req"); // R2
  AST_PIN_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rst_ni |-> irst_o) else $error("pin"); // R2
  AST_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irst_o) |-> $past(!any_req)) else $error("drop"); // R3
  AST_CLR_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_clr_o |-> irst_o) else $error("clr"); // R4
  AST_VEC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_lo_o == vec_hi_o + 16'd1) else $error("vec"); // R5
  AST_POR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |=> status_o == 8'h80) else $error("por"); // R8
  AST_WDOG_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_req_i && !por_req_i) |=> status_o[B_WDOG]) else $error("wdog"); // R1
  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_rd_i) && !any_req && !irst_o) |=> status_o == '0) else $error("rd"); // R9
endmodule

bind reset_source_ctrl rsc_checker u_rsc_checker (.*);

// File: tb/reset_source_ctrl_test.sv
module reset_source_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, pin_n = 1'b1;
  logic por = 0, wdog = 0, lvi = 0, iop = 0, iad = 0, mon = 0, rd = 0;
  logic irst, clr;
  logic [15:0] vhi, vlo;
  logic [7:0]  stat;
  int checks = 0, fails = 0;
  logic [7:0] exp_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_source_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_rst_ni(pin_n), .por_req_i(por),
    .wdog_req_i(wdog), .lvi_req_i(lvi), .ill_op_req_i(iop), .ill_addr_req_i(iad),
    .monitor_i(mon), .stat_rd_i(rd), .irst_o(irst), .psc_clr_o(clr),
    .vec_hi_o(vhi), .vec_lo_o(vlo), .status_o(stat)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] src_bit(int k);
    case (k)
      0: return 8'h80; 1: return 8'h20; 2: return 8'h10;
      3: return 8'h08; default: return 8'h04;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(logic m, logic lo);
    return {m ? 8'hFE : 8'hFF, lo ? 8'hFF : 8'hFE};
  endfunction

  // one-clock pulse on source k; returns half a clock after the sampling edge
  task automatic pulse(int k);
    @(negedge clk);
    case (k) 0: por = 1; 1: wdog = 1; 2: iop = 1; 3: iad = 1; default: lvi = 1; endcase
    @(negedge clk);
    {por, wdog, iop, iad, lvi} = '0;
  endtask

  task automatic rd_clear();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    @(negedge clk);
    chk("R9", stat, 8'h00);
    exp_stat = '0;
  endtask

  task automatic pin_low(int len, output int clr_seen);
    clr_seen = 0;
    @(negedge clk); pin_n = 0;
    #1 chk("R2", irst, 1'b1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (clr) clr_seen++;
    end
    pin_n = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clr) clr_seen++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cs;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R2", irst, 1'b0);
    chk("R4", clr, 1'b0);
    chk("R1", stat, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // vectors
    chk("R5", vhi, 16'hFFFE); chk("R5", vlo, 16'hFFFF);
    mon = 1; #1;
    chk("R5", vhi, 16'hFEFE); chk("R5", vlo, 16'hFEFF);
    mon = 0;

    // release timing with watchdog
    pulse(1);
    chk("R2", irst, 1'b1); chk("R4", clr, 1'b1); chk("R1", stat, 8'h20);
    repeat (31) @(negedge clk);
    chk("R3", irst, 1'b1); chk("R4", clr, 1'b1);
    @(negedge clk);
    chk("R3", irst, 1'b0); chk("R4", clr, 1'b0);
    rd_clear();

    // POR clears other bits
    pulse(2); pulse(4);
    chk("R1", stat, 8'h14);
    pulse(0);
    chk("R8", stat, 8'h80);
    repeat (40) @(negedge clk);
    rd_clear();

    // pin threshold boundaries
    pin_low(66, cs);
    chk("R6", stat, 8'h00); chk("R4", cs, 0); chk("R3", irst, 1'b0);
    pin_low(67, cs);
    chk("R6", stat, 8'h40); chk("R4", cs, 0);
    rd_clear();
    pin_low(100, cs);
    chk("R6", stat, 8'h40);
    rd_clear();

    // pin masked by low-voltage / power-on in the same reset
    pulse(4);
    pin_low(80, cs);
    chk("R7", stat, 8'h04); chk("R4", cs > 0, 1'b1);
    rd_clear();
    pulse(0);
    pin_low(80, cs);
    chk("R7", stat, 8'h80);
    rd_clear();

    // read strobe loses against a same-edge set
    pulse(1);
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0; iop = 1;
    @(negedge clk); iop = 0;
    chk("R9", stat, 8'h10);
    repeat (40) @(negedge clk);
    rd_clear();

    // random source sequences against model
    for (int t = 0; t < 40; t++) begin
      int k = $urandom_range(0, 4);
      pulse(k);
      exp_stat = (k == 0) ? 8'h80 : (exp_stat | src_bit(k));
      chk("R1", stat, exp_stat);
      chk("R1", stat[1:0], 2'b00);
      if ($urandom_range(0, 3) == 0) begin
        repeat (40) @(negedge clk);
        chk("R3", irst, 1'b0);
        rd_clear();
      end
      mon = 1'($urandom_range(0, 1)); #1;
      chk("R5", vhi, exp_vec(mon, 1'b0));
      chk("R5", vlo, exp_vec(mon, 1'b1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule